// File: doc/BRIEF.md
# Bus Transfer Cycle Sequencer

This block sits between a processor's memory-access port and the controller of a 16-bit external bus. It takes one access request (byte, word or longword, read or write, optionally a locked read-modify-write pair) and turns it into the ordered list of bus cycle types the bus controller must run. The electrical handshake and bus arbitration are outside the block: the bus side only sees a cycle command and answers each cycle with a completion pulse and, for reads, the data.

A longword transfer goes out as one 32-bit block cycle when the target can take block transfers. Otherwise the longword is split into two 16-bit cycles, low half first, with the second cycle aimed two bytes higher. A locked request is issued as its read phase followed by its write phase. Whenever a request needs more than one cycle, a bus-hold output stays high from the first cycle to the last, so bus ownership is never released inside the sequence. After the final cycle a one-clock done pulse is given, and the read data, assembled to 32 bits, is presented.

Top module: `bus_cycle_seq`

## Requirements
- R1: Unlocked single-cycle requests map to cycle types on `cyc_type`: byte write gives 1 (8-bit out), word read gives 2 (16-bit in), word write gives 3 (16-bit out), longword read to a block-capable target gives 4 (32-bit block in), longword write to a block-capable target gives 5 (32-bit block out); `req_size` 0 is byte, 1 is word, 2 and 3 are longword; `cyc_type` is 0 when no cycle is commanded.
- R2: A byte read is issued as one type 2 cycle whose `cyc_addr` equals the request address, bit 0 included.
- R3: A locked request runs its read phase and then its write phase: a locked word gives types 2 then 3, a locked block longword gives types 4 then 5, a locked byte gives types 2 then 1.
- R4: A longword to a target without block capability runs as two 16-bit cycles (type 2 for reads, 3 for writes): the first with `cyc_hi`=0 at the request address, the second with `cyc_hi`=1 at the request address plus 2 (modulo the address width); a locked one runs 2,2,3,3 with `cyc_hi` 0,1,0,1.
- R5: `bus_hold` is high in every cycle of a sequence of two or more bus cycles, including the idle gaps between them, and is low when idle and throughout single-cycle sequences.
- R6: One clock after the completion pulse of the final cycle, `done` is high for exactly one clock, `cyc_valid` is low, and `rd_data` holds: the whole 32-bit bus data for a block read; {second half, first half} for a split read; the 16-bit value zero-extended for a 16-bit read; zero for a request with no read phase.
- R7: `cyc_wdata` carries the whole write data on type 5, write bits 31:16 in its low half on a `cyc_hi` write cycle, write bits 15:0 in its low half on other write cycles, with the upper half zero on all 16-bit and 8-bit cycles.
- R8: `req_ready` is low while a sequence runs and requests presented then are ignored; `cyc_done` pulses while idle produce no `done` and leave `rd_data` unchanged.
- R9: After reset: `req_ready` high, `cyc_valid`, `bus_hold` and `done` low, `cyc_type` 0, `rd_data` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken this clock |
| req_write | input | 1 | 1 = write (ignored for locked requests) |
| req_size | input | 2 | 0 byte, 1 word, 2/3 longword |
| req_lock | input | 1 | Locked read followed by unlocking write |
| req_block | input | 1 | Target accepts 32-bit block cycles |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 2*HW | Write data |
| cyc_valid | output | 1 | A bus cycle is commanded |
| cyc_type | output | 3 | Cycle type code |
| cyc_hi | output | 1 | Upper half of a split pair (address offset +2) |
| cyc_addr | output | ADDR_W | Address of the current cycle |
| cyc_wdata | output | 2*HW | Data for the current write cycle |
| cyc_done | input | 1 | Current cycle completed |
| cyc_rdata | input | 2*HW | Read data of the completing cycle |
| bus_hold | output | 1 | Keep bus ownership across the sequence |
| done | output | 1 | One-clock pulse after the final cycle |
| rd_data | output | 2*HW | Assembled read data |

## Verification
Two functions meet in one clock at each cycle boundary: the completion that ends one cycle also selects the next command, while bus-hold must stay asserted and the read assembler captures the finished half. The bench sweeps every combination of direction, size, lock and block capability, with gaps of zero to two clocks between commands and completions, so that a completion arriving in the first clock a command is shown is exercised next to delayed ones, and judges the command, address, write data and hold at every step and the assembled data at the end against values derived from the request. Stray requests are pushed into the gaps to show that a new request and a running sequence never mix.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

   typedef enum logic [2:0] {
      CT_NONE  = 3'd0,
      CT_OUT8  = 3'd1,
      CT_IN16  = 3'd2,
      CT_OUT16 = 3'd3,
      CT_IN32  = 3'd4,
      CT_OUT32 = 3'd5
   } cyc_t;

   typedef struct packed {
      logic       write;
      logic [1:0] size;
      logic       lock;
      logic       block;
   } req_attr_t;

   typedef struct packed {
      cyc_t ctype;
      logic hi;
      logic rd;
   } step_t;

   localparam int MAX_STEPS = 4;
   localparam int STEP_W    = $clog2(MAX_STEPS);
   localparam int CNT_W     = STEP_W + 1;

   function automatic logic is_write_type(cyc_t t);
      return (t == CT_OUT8) || (t == CT_OUT16) || (t == CT_OUT32);
   endfunction

endpackage

// File: rtl/bcs_plan.sv
module bcs_plan
   import bcs_pkg::*;
#(
   parameter bit ALLOW_BLOCK = 1'b1
) (
   input  req_attr_t                    attr,
   output logic [CNT_W-1:0]             n_steps,
   output step_t [MAX_STEPS-1:0]        steps
);

   logic eff_block;
   logic is_long;
   logic split;
   int   per;

   generate
      if (ALLOW_BLOCK) begin : g_blk
         assign eff_block = attr.block;
      end else begin : g_noblk
         assign eff_block = 1'b0;
      end
   endgenerate

   assign is_long = attr.size[1];
   assign split   = is_long & ~eff_block;
   assign per     = split ? 2 : 1;
   assign n_steps = CNT_W'(per << attr.lock);

   generate
      for (genvar k = 0; k < MAX_STEPS; k++) begin : g_step
         logic phase_wr;
         assign phase_wr = attr.lock ? (k >= per) : attr.write;
         always_comb begin
            steps[k].hi = split & (k % 2 == 1);
            steps[k].rd = ~phase_wr;
            if (phase_wr) begin
               case (attr.size)
                  2'd0:    steps[k].ctype = CT_OUT8;
                  2'd1:    steps[k].ctype = CT_OUT16;
                  default: steps[k].ctype = split ? CT_OUT16 : CT_OUT32;
               endcase
            end else begin
               steps[k].ctype = (is_long & ~split) ? CT_IN32 : CT_IN16;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
   import bcs_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              cyc_done,
   input  logic [CNT_W-1:0]  n_steps,
   output logic              busy,
   output logic [STEP_W-1:0] step,
   output logic              last,
   output logic              done
);

   assign last = ({1'b0, step} == n_steps - CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         step <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            busy <= 1'b1;
            step <= '0;
         end else if (busy && cyc_done) begin
            if (last) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               step <= step + STEP_W'(1);
            end
         end
      end
   end

   // R6: completion indication lasts one clock only
   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8: a new request is only taken when no sequence runs
   a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !(cyc_done && last)) |=> busy);

endmodule

// File: rtl/bcs_rdasm.sv
module bcs_rdasm
   import bcs_pkg::*;
#(
   parameter int HW = 16,
   localparam int WW = 2 * HW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          capture,
   input  cyc_t          ctype,
   input  logic          hi,
   input  logic [WW-1:0] rdata,
   output logic [WW-1:0] rd_data
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (clear) begin
         rd_data <= '0;
      end else if (capture) begin
         if (ctype == CT_IN32)
            rd_data <= rdata;
         else if (hi)
            rd_data[WW-1:HW] <= rdata[HW-1:0];
         else
            rd_data[HW-1:0] <= rdata[HW-1:0];
      end
   end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
   import bcs_pkg::*;
#(
   parameter int ADDR_W      = 22,
   parameter int HW          = 16,
   parameter bit ALLOW_BLOCK = 1'b1,
   localparam int WW = 2 * HW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic              req_lock,
   input  logic              req_block,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [WW-1:0]     req_wdata,
   output logic              cyc_valid,
   output logic [2:0]        cyc_type,
   output logic              cyc_hi,
   output logic [ADDR_W-1:0] cyc_addr,
   output logic [WW-1:0]     cyc_wdata,
   input  logic              cyc_done,
   input  logic [WW-1:0]     cyc_rdata,
   output logic              bus_hold,
   output logic              done,
   output logic [WW-1:0]     rd_data
);

   generate
      if (HW < 8) begin : g_chk_hw
         $error("bus_cycle_seq: HW must be at least 8");
      end
      if (ADDR_W < 2) begin : g_chk_aw
         $error("bus_cycle_seq: ADDR_W must be at least 2");
      end
   endgenerate

   localparam logic [ADDR_W-1:0] HALF_OFS = ADDR_W'(HW / 8);

   req_attr_t             attr_q;
   logic [ADDR_W-1:0]     addr_q;
   logic [WW-1:0]         wdata_q;
   logic                  busy;
   logic                  last;
   logic                  accept;
   logic [STEP_W-1:0]     step;
   logic [CNT_W-1:0]      n_steps;
   step_t [MAX_STEPS-1:0] steps;
   step_t                 cur;

   assign req_ready = ~busy;
   assign accept    = req_valid & ~busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         attr_q  <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         attr_q  <= '{write: req_write, size: req_size, lock: req_lock, block: req_block};
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   bcs_plan #(.ALLOW_BLOCK(ALLOW_BLOCK)) u_plan (
      .attr    (attr_q),
      .n_steps (n_steps),
      .steps   (steps)
   );

   bcs_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .cyc_done (cyc_done),
      .n_steps  (n_steps),
      .busy     (busy),
      .step     (step),
      .last     (last),
      .done     (done)
   );

   assign cur       = steps[step];
   assign cyc_valid = busy;
   assign cyc_type  = busy ? cur.ctype : CT_NONE;
   assign cyc_hi    = busy & cur.hi;
   assign cyc_addr  = addr_q + (cyc_hi ? HALF_OFS : '0);
   assign bus_hold  = busy & (n_steps > CNT_W'(1));

   always_comb begin
      cyc_wdata = '0;
      if (busy && is_write_type(cur.ctype)) begin
         if (cur.ctype == CT_OUT32)
            cyc_wdata = wdata_q;
         else if (cur.hi)
            cyc_wdata[HW-1:0] = wdata_q[WW-1:HW];
         else
            cyc_wdata[HW-1:0] = wdata_q[HW-1:0];
      end
   end

   bcs_rdasm #(.HW(HW)) u_rdasm (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (accept),
      .capture (busy & cyc_done & cur.rd),
      .ctype   (cur.ctype),
      .hi      (cur.hi),
      .rdata   (cyc_rdata),
      .rd_data (rd_data)
   );

   // R6: the end of a command is followed at once by the done pulse
   a_r6_done_after_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cyc_valid) |-> done);

   // R4: the upper-half select only appears on 16-bit cycles
   a_r4_hi_is_half: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_valid && cyc_hi) |-> (cyc_type == CT_IN16 || cyc_type == CT_OUT16));

   // R5: hold stays up and a command follows when a non-final cycle ends
   a_r5_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_hold && cyc_done && !last) |=> (bus_hold && cyc_valid));

   // R8: ready and an active command never coincide
   a_r8_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !cyc_valid);

   // R1: an active command always carries a real cycle type
   a_r1_type_known: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_valid |-> (cyc_type != CT_NONE && cyc_type <= CT_OUT32));

endmodule

// File: tb/sim_bus_cycle_seq.sv
module sim_bus_cycle_seq;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 22;
   localparam int HW         = 16;
   localparam int WW         = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic              req_write = 1'b0;
   logic [1:0]        req_size = '0;
   logic              req_lock = 1'b0;
   logic              req_block = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [WW-1:0]     req_wdata = '0;
   logic              cyc_valid;
   logic [2:0]        cyc_type;
   logic              cyc_hi;
   logic [ADDR_W-1:0] cyc_addr;
   logic [WW-1:0]     cyc_wdata;
   logic              cyc_done = 1'b0;
   logic [WW-1:0]     cyc_rdata = '0;
   logic              bus_hold;
   logic              done;
   logic [WW-1:0]     rd_data;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   bus_cycle_seq u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_size(req_size), .req_lock(req_lock),
      .req_block(req_block), .req_addr(req_addr), .req_wdata(req_wdata),
      .cyc_valid(cyc_valid), .cyc_type(cyc_type), .cyc_hi(cyc_hi),
      .cyc_addr(cyc_addr), .cyc_wdata(cyc_wdata), .cyc_done(cyc_done),
      .cyc_rdata(cyc_rdata), .bus_hold(bus_hold), .done(done), .rd_data(rd_data)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic int e_per(logic [1:0] s, logic b);
      return (s[1] && !b) ? 2 : 1;
   endfunction

   function automatic int e_n(logic [1:0] s, logic l, logic b);
      return e_per(s, b) * (l ? 2 : 1);
   endfunction

   function automatic logic [2:0] e_type(logic w, logic [1:0] s, logic l, logic b, int k);
      logic wr;
      bit   split;
      split = s[1] && !b;
      wr = l ? (k >= e_per(s, b)) : w;
      if (wr) begin
         if (s == 2'd0) return 3'd1;
         if (s == 2'd1) return 3'd3;
         return split ? 3'd3 : 3'd5;
      end
      return (s[1] && !split) ? 3'd4 : 3'd2;
   endfunction

   function automatic logic [WW-1:0] e_rdv(int idx, int k);
      return 32'hA5A5_0000 ^ (idx * 32'h0101_0101 + k * 32'h0001_3579);
   endfunction

   task automatic run_req(input int idx);
      logic             w, l, b, hi, rdph, split;
      logic [1:0]       s;
      logic [2:0]       t;
      logic [ADDR_W-1:0] a, ea;
      logic [WW-1:0]    wd, ewd, erd;
      int               n, per;
      w = idx[0]; s = idx[2:1]; l = idx[3]; b = idx[4];
      a  = (idx == 31) ? {{(ADDR_W-1){1'b1}}, 1'b0} : ADDR_W'(idx * 4661 + idx[0]);
      wd = 32'hC0DE_0000 + idx * 32'h0102_0304;
      n = e_n(s, l, b);
      per = e_per(s, b);
      split = s[1] && !b;
      rdph = l || !w;
      if (!rdph) erd = '0;
      else if (s[1] && !split) erd = e_rdv(idx, 0);
      else if (split) erd = {e_rdv(idx, 1)[15:0], e_rdv(idx, 0)[15:0]};
      else erd = {16'h0, e_rdv(idx, 0)[15:0]};

      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_size = s; req_lock = l;
      req_block = b; req_addr = a; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < n; k++) begin
         t  = e_type(w, s, l, b, k);
         hi = split && (k % 2 == 1);
         ea = a + (hi ? ADDR_W'(2) : ADDR_W'(0));
         if (t == 3'd5) ewd = wd;
         else if (t == 3'd1 || t == 3'd3) ewd = hi ? {16'h0, wd[31:16]} : {16'h0, wd[15:0]};
         else ewd = '0;
         chk(cyc_valid === 1'b1, "R1", "cyc_valid", 64'(cyc_valid), 64'd1);
         chk(cyc_type === t, (l ? "R3" : (split ? "R4" : "R1")), "cyc_type", 64'(cyc_type), 64'(t));
         chk(cyc_hi === hi, "R4", "cyc_hi", 64'(cyc_hi), 64'(hi));
         chk(cyc_addr === ea, (s == 2'd0 ? "R2" : "R4"), "cyc_addr", 64'(cyc_addr), 64'(ea));
         chk(cyc_wdata === ewd, "R7", "cyc_wdata", 64'(cyc_wdata), 64'(ewd));
         chk(bus_hold === (n > 1), "R5", "bus_hold", 64'(bus_hold), 64'(n > 1));
         for (int j = 0; j < (idx + k) % 3; j++) begin
            req_valid = 1'b1; req_write = ~w; req_size = ~s; req_addr = ~a;
            @(negedge clk);
            req_valid = 1'b0;
            chk(req_ready === 1'b0, "R8", "req_ready busy", 64'(req_ready), 64'd0);
            chk(cyc_type === t && cyc_addr === ea, "R8", "cmd kept", 64'(cyc_addr), 64'(ea));
            chk(bus_hold === (n > 1), "R5", "bus_hold gap", 64'(bus_hold), 64'(n > 1));
         end
         cyc_done = 1'b1; cyc_rdata = e_rdv(idx, k);
         @(negedge clk);
         cyc_done = 1'b0; cyc_rdata = '0;
      end
      chk(done === 1'b1, "R6", "done", 64'(done), 64'd1);
      chk(rd_data === erd, "R6", "rd_data", 64'(rd_data), 64'(erd));
      chk(cyc_valid === 1'b0, "R6", "cyc_valid end", 64'(cyc_valid), 64'd0);
      chk(bus_hold === 1'b0, "R5", "bus_hold end", 64'(bus_hold), 64'd0);
      chk(req_ready === 1'b1, "R8", "req_ready end", 64'(req_ready), 64'd1);
      cyc_done = 1'b1; cyc_rdata = 32'hFFFF_FFFF;
      @(negedge clk);
      cyc_done = 1'b0; cyc_rdata = '0;
      chk(done === 1'b0, "R6", "done one clock", 64'(done), 64'd0);
      @(negedge clk);
      chk(done === 1'b0, "R8", "idle cyc_done no done", 64'(done), 64'd0);
      chk(rd_data === erd, "R8", "idle cyc_done rd_data", 64'(rd_data), 64'(erd));
      chk(cyc_type === 3'd0, "R1", "idle type", 64'(cyc_type), 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(req_ready === 1'b1, "R9", "reset req_ready", 64'(req_ready), 64'd1);
      chk(cyc_valid === 1'b0, "R9", "reset cyc_valid", 64'(cyc_valid), 64'd0);
      chk(bus_hold === 1'b0, "R9", "reset bus_hold", 64'(bus_hold), 64'd0);
      chk(done === 1'b0, "R9", "reset done", 64'(done), 64'd0);
      chk(cyc_type === 3'd0, "R9", "reset cyc_type", 64'(cyc_type), 64'd0);
      chk(rd_data === '0, "R9", "reset rd_data", 64'(rd_data), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int rep = 0; rep < 2; rep++)
         for (int idx = 0; idx < 32; idx++)
            run_req(idx);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule